// File: doc/BRIEF.md
# Queue Threshold Interrupt Status Register

This block is the 32-bit interrupt status word of the programmed-I/O path in an I3C host controller. Two of its bits record events. The bus engine reports a transfer error or an aborted transfer with a one-cycle pulse, and the matching bit stays set until software clears it by writing zero to it. Five other bits follow queue fill levels. Each one compares a live queue count with a threshold that software programs elsewhere, and the comparison is registered every cycle. The five queues are the response queue, the command queue (counted as empty slots), the IBI status queue, the receive data queue and the transmit data queue (counted as available slots).

Software reaches the register through a plain register bus. The bus has an address, a write enable and write data, and it returns read data without a wait state. An interrupt line is the OR of all status bits that a separate enable mask lets through. The line is registered.

Top module: `pio_intr_stat`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every register bit reads 0 and `irq_o` is 0.
- R2: Bit 9 (error) becomes 1 on the edge after `xfer_err_i` is high. It then holds. A write to the register address with wdata bit 9 = 0 clears it on the next edge. A write with bit 9 = 1 leaves it unchanged.
- R3: Bit 5 (abort) behaves the same way as bit 9, driven by `xfer_abort_i` and cleared through wdata bit 5.
- R4: When an event pulse and a clear-by-zero write for the same bit meet in one cycle, the bit is 1 after the edge.
- R5: Bit 4 is 1 exactly when, on the previous edge, the response count was ≥ the response threshold.
- R6: Bit 3 is 1 exactly when, on the previous edge, the empty command count was ≥ its threshold.
- R7: Bit 2 is 1 exactly when, on the previous edge, the IBI status count was ≥ its threshold.
- R8: Bit 1 is 1 exactly when, on the previous edge, the receive count was ≥ its threshold.
- R9: Bit 0 is 1 exactly when, on the previous edge, the available transmit count was ≥ its threshold.
- R10: Writes have no effect on bits 4:0 or on the reserved bits (31:10 and 8:6). The reserved bits always read 0.
- R11: `irq_o` equals the OR over (status & `irq_en_i`) as it was on the previous edge.
- R12: `rdata_o` is 0 when `addr_i` differs from the register offset (default 0x0E0). Writes to any other address change nothing.
- R13: A threshold change takes effect on its level bit at the next edge. The same holds for a count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register bus byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| xfer_err_i | input | 1 | Transfer error pulse |
| xfer_abort_i | input | 1 | Transfer aborted pulse |
| resp_cnt_i | input | 5 | Response queue entries |
| resp_thr_i | input | 5 | Response threshold |
| cmd_empty_cnt_i | input | 5 | Empty command queue entries |
| cmd_thr_i | input | 5 | Command-empty threshold |
| ibi_cnt_i | input | 5 | IBI status entries |
| ibi_thr_i | input | 5 | IBI status threshold |
| rx_cnt_i | input | 5 | Receive data queue entries |
| rx_thr_i | input | 5 | Receive threshold |
| tx_avail_cnt_i | input | 5 | Available transmit queue entries |
| tx_thr_i | input | 5 | Transmit threshold |
| irq_en_i | input | 32 | Interrupt enable mask, one bit per status bit |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Registered interrupt |

## Verification
A sticky bit stuck at zero or failing to clear, or a comparison with the wrong direction or the wrong equality, shows in the read data at the first sampled cycle after the stimulus. This is because every status bit sits one register from its inputs. An interrupt path that is combinational, or that ignores the mask, shows as `irq_o` disagreeing with the previous cycle's masked status. The bench holds every corner in which two causes meet in one cycle: a pulse against a clear, counts equal to their thresholds, and writes at a foreign address.

// File: rtl/pio_intr_stat_pkg.sv
package pio_intr_stat_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_LVL   = 5;
  localparam int unsigned NUM_EVT   = 2;
  localparam int unsigned BIT_ERR   = 9;
  localparam int unsigned BIT_ABORT = 5;
  // level bit positions = queue index
  localparam int unsigned LVL_TX    = 0;
  localparam int unsigned LVL_RX    = 1;
  localparam int unsigned LVL_IBI   = 2;
  localparam int unsigned LVL_CMD   = 3;
  localparam int unsigned LVL_RESP  = 4;

  function automatic logic [REG_W-1:0] stat_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LVL; i++) m[i] = 1'b1;
    m[BIT_ERR]   = 1'b1;
    m[BIT_ABORT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pio_lvl_cmp.sv
module pio_lvl_cmp #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= (cnt_i >= thr_i);
  end

  assign lvl_o = lvl_q;

  // R5 R6 R7 R8 R9 R13 (one instance per queue)
  lvl_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_i) < $past(thr_i)) |-> !lvl_o);
  // R5 R6 R7 R8 R9 R13
  lvl_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(cnt_i) >= $past(thr_i))) |-> lvl_o);
endmodule

// File: rtl/pio_sticky_bit.sv
module pio_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic st_o
);
  logic st_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= 1'b0;
    else if (evt_i) st_q <= 1'b1;
    else if (clr_i) st_q <= 1'b0;
  end

  assign st_o = st_q;

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(evt_i && rst_ni) |-> st_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o && !clr_i) |=> st_o);
  // R2
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !st_o);
endmodule

// File: rtl/pio_intr_stat.sv
module pio_intr_stat
  import pio_intr_stat_pkg::*;
#(
  parameter int unsigned          ADDR_W = 12,
  parameter int unsigned          CNT_W  = 5,
  parameter logic [ADDR_W-1:0]    OFFSET = 12'h0E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              xfer_err_i,
  input  logic              xfer_abort_i,
  input  logic [CNT_W-1:0]  resp_cnt_i,
  input  logic [CNT_W-1:0]  resp_thr_i,
  input  logic [CNT_W-1:0]  cmd_empty_cnt_i,
  input  logic [CNT_W-1:0]  cmd_thr_i,
  input  logic [CNT_W-1:0]  ibi_cnt_i,
  input  logic [CNT_W-1:0]  ibi_thr_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  rx_thr_i,
  input  logic [CNT_W-1:0]  tx_avail_cnt_i,
  input  logic [CNT_W-1:0]  tx_thr_i,
  input  logic [REG_W-1:0]  irq_en_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] STAT_MASK = stat_mask();
  localparam int unsigned EVT_POS [NUM_EVT] = '{BIT_ERR, BIT_ABORT};

  logic             addr_hit, wr_hit;
  logic [CNT_W-1:0] cnt_a [NUM_LVL];
  logic [CNT_W-1:0] thr_a [NUM_LVL];
  logic [NUM_LVL-1:0] lvl;
  logic [NUM_EVT-1:0] evt, sticky;
  logic [REG_W-1:0] stat;
  logic             irq_q;

  assign addr_hit = (addr_i == OFFSET);
  assign wr_hit   = we_i && addr_hit;

  assign cnt_a[LVL_TX]   = tx_avail_cnt_i;
  assign thr_a[LVL_TX]   = tx_thr_i;
  assign cnt_a[LVL_RX]   = rx_cnt_i;
  assign thr_a[LVL_RX]   = rx_thr_i;
  assign cnt_a[LVL_IBI]  = ibi_cnt_i;
  assign thr_a[LVL_IBI]  = ibi_thr_i;
  assign cnt_a[LVL_CMD]  = cmd_empty_cnt_i;
  assign thr_a[LVL_CMD]  = cmd_thr_i;
  assign cnt_a[LVL_RESP] = resp_cnt_i;
  assign thr_a[LVL_RESP] = resp_thr_i;

  assign evt = {xfer_abort_i, xfer_err_i};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    pio_lvl_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt_a[g]),
      .thr_i (thr_a[g]),
      .lvl_o (lvl[g])
    );
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    pio_sticky_bit u_st (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt[g]),
      .clr_i (wr_hit && !wdata_i[EVT_POS[g]]),
      .st_o  (sticky[g])
    );
  end

  always_comb begin
    stat = '0;
    for (int i = 0; i < NUM_LVL; i++) stat[i] = lvl[i];
    for (int i = 0; i < NUM_EVT; i++) stat[EVT_POS[i]] = sticky[i];
  end

  assign rdata_o = addr_hit ? stat : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat & irq_en_i);
  end

  assign irq_o = irq_q;

  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~STAT_MASK) == '0);
  // R11
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & irq_en_i) == '0) |=> !irq_o);
  // R11
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & irq_en_i) != '0) |=> irq_o);
  // R12
  miss_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_hit && (evt == '0)) |=> $stable(sticky));
endmodule

// File: tb/pio_intr_stat_bench.sv
`timescale 1ns/1ps
module pio_intr_stat_bench;
  localparam logic [11:0] OFF = 12'h0E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = OFF;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        err = 1'b0, abt = 1'b0;
  logic [4:0]  cnt [5];
  logic [4:0]  thr [5];
  logic [31:0] en = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_err, m_abt, m_irq;
  bit m_lvl [5];

  always #2.5 clk = ~clk;

  pio_intr_stat u_pio_intr_stat (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .xfer_err_i(err), .xfer_abort_i(abt),
    .resp_cnt_i(cnt[4]), .resp_thr_i(thr[4]),
    .cmd_empty_cnt_i(cnt[3]), .cmd_thr_i(thr[3]),
    .ibi_cnt_i(cnt[2]), .ibi_thr_i(thr[2]),
    .rx_cnt_i(cnt[1]), .rx_thr_i(thr[1]),
    .tx_avail_cnt_i(cnt[0]), .tx_thr_i(thr[0]),
    .irq_en_i(en), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_stat();
    logic [31:0] s = '0;
    for (int i = 0; i < 5; i++) s[i] = m_lvl[i];
    s[9] = m_err;
    s[5] = m_abt;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    logic [31:0] s = m_stat();
    if (addr == OFF) begin
      chk("R2 error bit",   32'(rdata[9]), 32'(s[9]));
      chk("R3 abort bit",   32'(rdata[5]), 32'(s[5]));
      chk("R5 resp bit",    32'(rdata[4]), 32'(s[4]));
      chk("R6 cmd bit",     32'(rdata[3]), 32'(s[3]));
      chk("R7 ibi bit",     32'(rdata[2]), 32'(s[2]));
      chk("R8 rx bit",      32'(rdata[1]), 32'(s[1]));
      chk("R9 tx bit",      32'(rdata[0]), 32'(s[0]));
      chk("R10 reserved",   rdata & 32'hFFFF_FDC0, 32'h0);
    end else begin
      chk("R12 miss read", rdata, 32'h0);
    end
    chk("R11 irq", 32'(irq), 32'(m_irq));
  endtask

  // one clock: model follows the edge, compare at the falling edge
  task automatic tick();
    logic [31:0] s;
    bit clr_e, clr_a;
    @(posedge clk);
    s = m_stat();
    clr_e = we && (addr == OFF) && !wdata[9];
    clr_a = we && (addr == OFF) && !wdata[5];
    m_irq = |(s & en);
    m_err = err ? 1'b1 : (clr_e ? 1'b0 : m_err);
    m_abt = abt ? 1'b1 : (clr_a ? 1'b0 : m_abt);
    for (int i = 0; i < 5; i++) m_lvl[i] = (cnt[i] >= thr[i]);
    @(negedge clk);
    chk_all();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0; addr = OFF;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin cnt[i] = '0; thr[i] = '0; m_lvl[i] = 0; end
    m_err = 0; m_abt = 0; m_irq = 0;
    err = 1'b1; abt = 1'b1; en = '1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);
    err = 1'b0; abt = 1'b0;
    thr[4] = 5'd3; thr[3] = 5'd4; thr[2] = 5'd2; thr[1] = 5'd5; thr[0] = 5'd1;
    rst_n = 1'b1;
    tick();
    chk("R1 first cycle", rdata, 32'h0);

    // R5 R6 R7 R8 R9: ramp all counts through their thresholds
    for (int v = 0; v < 9; v++) begin
      for (int i = 0; i < 5; i++) cnt[i] = 5'(v);
      tick();
    end
    for (int v = 8; v >= 0; v--) begin
      for (int i = 0; i < 5; i++) cnt[i] = 5'(v);
      tick();
    end

    // R13: threshold change takes effect at the next edge
    cnt[1] = 5'd5; thr[1] = 5'd6; tick();
    chk("R13 thr raised", 32'(rdata[1]), 32'h0);
    thr[1] = 5'd5; tick();
    chk("R13 thr equal", 32'(rdata[1]), 32'h1);
    thr[1] = 5'd31; cnt[1] = 5'd31; tick();
    chk("R13 max equal", 32'(rdata[1]), 32'h1);

    // R2: error sticky, write 1 keeps, write 0 clears
    err = 1'b1; tick(); err = 1'b0;
    repeat (3) tick();
    chk("R2 held", 32'(rdata[9]), 32'h1);
    wr(OFF, 32'h0000_0200);
    chk("R2 write one keeps", 32'(rdata[9]), 32'h1);
    wr(OFF, 32'h0);
    chk("R2 write zero clears", 32'(rdata[9]), 32'h0);

    // R3: abort
    abt = 1'b1; tick(); abt = 1'b0; tick();
    chk("R3 held", 32'(rdata[5]), 32'h1);
    wr(OFF, 32'hFFFF_FFFF);
    chk("R3 write one keeps", 32'(rdata[5]), 32'h1);
    wr(OFF, 32'hFFFF_FFDF);
    chk("R3 write zero clears", 32'(rdata[5]), 32'h0);

    // R4: pulse meets clear
    err = 1'b1; abt = 1'b1; wr(OFF, 32'h0); err = 1'b0; abt = 1'b0;
    chk("R4 error set wins", 32'(rdata[9]), 32'h1);
    chk("R4 abort set wins", 32'(rdata[5]), 32'h1);

    // R12: foreign address neither clears nor reads
    wr(12'h0E4, 32'h0);
    tick();
    chk("R12 foreign write ignored", rdata & 32'h220, 32'h220);

    // R10: writes to level and reserved bits
    for (int i = 0; i < 5; i++) begin cnt[i] = 5'd0; thr[i] = 5'd1; end
    tick();
    wr(OFF, 32'hFFFF_FFFF);
    chk("R10 level bits unwritable", rdata & 32'h1F, 32'h0);
    chk("R10 reserved read zero", rdata & 32'hFFFF_FDC0, 32'h0);

    // R11: mask gating
    wr(OFF, 32'h0); en = '0; tick(); tick();
    chk("R11 idle no irq", 32'(irq), 32'h0);
    err = 1'b1; tick(); err = 1'b0; tick();
    chk("R11 masked", 32'(irq), 32'h0);
    en = 32'h0000_0200; tick();
    chk("R11 enabled", 32'(irq), 32'h1);
    en = 32'hFFFF_FDFF; tick(); tick();
    chk("R11 other bits only", 32'(irq), 32'h0);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      err = ($urandom_range(0, 7) == 0);
      abt = ($urandom_range(0, 7) == 0);
      we = ($urandom_range(0, 3) == 0);
      addr = ($urandom_range(0, 5) == 0) ? 12'(OFF + 12'd4) : OFF;
      wdata = $urandom;
      en = $urandom;
      for (int i = 0; i < 5; i++) begin
        if ($urandom_range(0, 1) == 0) cnt[i] = 5'($urandom_range(0, 31));
        if ($urandom_range(0, 7) == 0) thr[i] = 5'($urandom_range(0, 31));
      end
      tick();
    end
    we = 1'b0; err = 1'b0; abt = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule